// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This controller connects a simple requester to a 64K x 1 dynamic memory array that has only 8 address pins. A request carries a 16-bit address, a read/write flag and one write bit. The controller splits the address into two halves. It drives the upper half as the row and asserts the row strobe. It then drives the lower half as the column and asserts the column strobe. During the column phase it moves the single data bit in or out.

Stored charge in the array decays over time. An internal timer therefore raises a refresh request at a fixed interval in clock cycles. Each refresh is a row-strobe-only cycle that uses an 8-bit row counter, and the counter then advances. Over 256 refreshes every row is restored once.

A pending refresh goes ahead of any waiting access. The requester sees a ready signal and gets a one-cycle response pulse when each access completes.

Top module: `dram_mux_ctrl`

## Requirements
- R1: After reset, the row strobe, column strobe and write enable (all active-low) are high, `req_ready` is 1 and `rsp_valid` is 0.
- R2: When the row strobe falls for an access, `mem_addr` carries request address bits [15:8]. It holds that value for the whole row phase.
- R3: The column strobe falls only while the row strobe is low, and at least one clock after it. At that point `mem_addr` carries request address bits [7:0].
- R4: For a write (`req_write`=1), write enable is low only while the column strobe is low, and `mem_dout` carries the request bit. The array then holds that bit at the addressed location.
- R5: `rsp_valid` pulses high for one cycle, in the cycle right after the column strobe rises, and responses come in request order. For a read, `rsp_rdata` equals the bit last written to that address, or 0 if that address was never written.
- R6: Between one row-strobe low period and the next, both strobes stay high for at least PRE_CYC cycles.
- R7: A refresh cycle lowers only the row strobe and drives the refresh row counter on `mem_addr`. Successive refreshes use rows 0, 1, 2 and so on, wrapping from 255 back to 0.
- R8: A refresh starts at most REF_INTERVAL plus one access length after the previous one, so all 256 rows are refreshed within 256 intervals.
- R9: A pending refresh is served before a waiting access, even when the requester keeps `req_valid` high without a break.
- R10: `req_ready` is 0 whenever a strobe is low or a refresh is pending. A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Location; [15:8] row, [7:0] column |
| req_wdata | input | 1 | Bit to store |
| req_ready | output | 1 | Controller can take a request |
| rsp_valid | output | 1 | Access completed (one-cycle pulse) |
| rsp_rdata | output | 1 | Read bit, valid with rsp_valid |
| mem_addr | output | 8 | Shared row/column address bus |
| mem_ras_n | output | 1 | Row strobe, active-low |
| mem_cas_n | output | 1 | Column strobe, active-low |
| mem_we_n | output | 1 | Write enable, active-low |
| mem_dout | output | 1 | Data to array |
| mem_din | input | 1 | Data from array |

## Verification
On every cycle the assertions check the ordering between the strobes. This covers the column strobe nested inside the row strobe, write enable nested inside the column strobe, the precharge gap, the response position, the step of the refresh row and the ready gating. Other behaviours can only be shown by the bench scenarios driving a behavioural array. These are:
- that the right address halves reach the array;
- that data written can be read back;
- that the refresh rows cycle through all 256 values with bounded gaps;
- that refresh still happens under a continuous request stream.

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int ROW_W        = 8,
  parameter int REF_INTERVAL = 1560,
  parameter int RCD_CYC      = 2,
  parameter int CAS_CYC      = 2,
  parameter int PRE_CYC      = 2,
  parameter int REF_CYC      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [2*ROW_W-1:0]   req_addr,
  input  logic                 req_wdata,
  output logic                 req_ready,
  output logic                 rsp_valid,
  output logic                 rsp_rdata,
  output logic [ROW_W-1:0]     mem_addr,
  output logic                 mem_ras_n,
  output logic                 mem_cas_n,
  output logic                 mem_we_n,
  output logic                 mem_dout,
  input  logic                 mem_din
);
  localparam int AW   = 2 * ROW_W;
  localparam int TW   = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam int M1   = (RCD_CYC > CAS_CYC) ? RCD_CYC : CAS_CYC;
  localparam int M2   = (PRE_CYC > REF_CYC) ? PRE_CYC : REF_CYC;
  localparam int DMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(DMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_PRE, S_REF} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [TW-1:0]  tmr;
  logic           ref_pend;
  logic [ROW_W-1:0] ref_row, col_q;
  logic           wr_q, wd_q;
  logic           tick, last;

  assign tick      = tmr == TW'(REF_INTERVAL - 1);
  assign last      = cnt == '0;
  assign req_ready = (st == S_IDLE) && !ref_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr      <= '0;
      ref_pend <= 1'b0;
    end else begin
      tmr      <= tick ? '0 : tmr + 1'b1;
      ref_pend <= tick | (ref_pend & (st != S_IDLE));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      ref_row   <= '0;
      col_q     <= '0;
      wr_q      <= 1'b0;
      wd_q      <= 1'b0;
      mem_addr  <= '0;
      mem_ras_n <= 1'b1;
      mem_cas_n <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dout  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ref_pend) begin
            mem_addr  <= ref_row;
            mem_ras_n <= 1'b0;
            cnt       <= CW'(REF_CYC - 1);
            st        <= S_REF;
          end else if (req_valid) begin
            mem_addr  <= req_addr[AW-1:ROW_W];
            col_q     <= req_addr[ROW_W-1:0];
            wr_q      <= req_write;
            wd_q      <= req_wdata;
            mem_ras_n <= 1'b0;
            cnt       <= CW'(RCD_CYC - 1);
            st        <= S_ROW;
          end
        end
        S_ROW: begin
          if (last) begin
            mem_addr  <= col_q;
            mem_cas_n <= 1'b0;
            mem_we_n  <= ~wr_q;
            mem_dout  <= wd_q;
            cnt       <= CW'(CAS_CYC - 1);
            st        <= S_COL;
          end else cnt <= cnt - 1'b1;
        end
        S_COL: begin
          if (last) begin
            mem_ras_n <= 1'b1;
            mem_cas_n <= 1'b1;
            mem_we_n  <= 1'b1;
            rsp_valid <= 1'b1;
            rsp_rdata <= wr_q ? 1'b0 : mem_din;
            cnt       <= CW'(PRE_CYC - 1);
            st        <= S_PRE;
          end else cnt <= cnt - 1'b1;
        end
        S_REF: begin
          if (last) begin
            mem_ras_n <= 1'b1;
            ref_row   <= ref_row + 1'b1;
            cnt       <= CW'(PRE_CYC - 1);
            st        <= S_PRE;
          end else cnt <= cnt - 1'b1;
        end
        S_PRE: begin
          if (last) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= CW'(DMAX);
    else if (!mem_ras_n) hi_cnt <= '0;
    else if (hi_cnt != CW'(DMAX)) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_CAS_IN_RAS: assert property (@(posedge clk) disable iff (!rst_n) !mem_cas_n |-> !mem_ras_n); // R3
  AST_CAS_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_cas_n) |-> $past(!mem_ras_n)); // R3
  AST_WE_IN_CAS: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> !mem_cas_n); // R4
  AST_RSP_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $rose(mem_cas_n)); // R5
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_ras_n) |-> (hi_cnt >= CW'(PRE_CYC))); // R6
  AST_REF_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n) ($rose(mem_ras_n) && $past(st == S_REF)) |-> (ref_row == $past(ref_row) + 1'b1)); // R7
  AST_NO_LOST_REFRESH: assert property (@(posedge clk) disable iff (!rst_n) tick |-> !(ref_pend && st != S_IDLE)); // R8
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (mem_ras_n && mem_cas_n)); // R10
endmodule

// File: tb/dram_mux_ctrl_test.sv
module dram_mux_ctrl_test;
  localparam int REF_I = 60;
  localparam int PRE   = 2;
  localparam int SLACK = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
  logic [15:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_rdata;
  logic [7:0] mem_addr;
  logic mem_ras_n, mem_cas_n, mem_we_n, mem_dout, mem_din;

  always #2.5 clk = ~clk;

  dram_mux_ctrl #(.ROW_W(8), .REF_INTERVAL(REF_I), .RCD_CYC(2), .CAS_CYC(2),
                  .PRE_CYC(PRE), .REF_CYC(3)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_dout(mem_dout), .mem_din(mem_din));

  // behavioural array: row latched on row strobe fall, registered read data
  bit   arr [int];
  logic [7:0] m_row = '0;
  logic m_ras_q = 1'b1;
  logic din_q = 1'b0;
  assign mem_din = din_q;
  always @(posedge clk) begin
    m_ras_q <= mem_ras_n;
    if (!mem_ras_n && m_ras_q) m_row <= mem_addr;
    if (!mem_cas_n) begin
      if (!mem_we_n) arr[int'({m_row, mem_addr})] = mem_dout;
      din_q <= arr.exists(int'({m_row, mem_addr})) ? arr[int'({m_row, mem_addr})] : 1'b0;
    end
  end

  int total = 0, bad = 0;
  bit shadow [int];
  logic [15:0] addr_q [$];
  logic [1:0]  exp_q  [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input bit w, input logic [15:0] a, input bit d);
    bit e;
    e = 1'b0;
    if (w) shadow[int'(a)] = d;
    else if (shadow.exists(int'(a))) e = shadow[int'(a)];
    addr_q.push_back(a);
    exp_q.push_back({w, e});
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  logic p_ras = 1'b1, p_cas = 1'b1;
  logic [7:0] row_seen = '0;
  bit cas_seen = 1'b0;
  int hi_run = 1000, since_ref = 0, ref_cnt = 0, ras_low = 0;
  logic [7:0] exp_ref = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      since_ref++;
      if (!mem_ras_n && p_ras) begin
        chk(hi_run >= PRE, "R6 precharge", hi_run, PRE);
        row_seen = mem_addr; cas_seen = 1'b0; ras_low = 0;
      end
      if (!mem_ras_n) begin
        ras_low++;
        if (p_ras == 1'b0 && mem_addr != row_seen && mem_cas_n)
          chk(1'b0, "R2 row held", mem_addr, row_seen);
      end
      if (!mem_cas_n && p_cas) begin
        logic [15:0] ea;
        cas_seen = 1'b1;
        chk(!mem_ras_n && ras_low >= 2, "R3 cas after ras", ras_low, 2);
        if (addr_q.size() == 0) chk(1'b0, "R3 unexpected access", 0, 1);
        else begin
          ea = addr_q.pop_front();
          chk(row_seen == ea[15:8], "R2 row half", row_seen, ea[15:8]);
          chk(mem_addr == ea[7:0], "R3 column half", mem_addr, ea[7:0]);
        end
      end
      if (!mem_we_n && mem_cas_n) chk(1'b0, "R4 we outside cas", 0, 1);
      if (req_ready && (!mem_ras_n || !mem_cas_n)) chk(1'b0, "R10 ready while busy", 1, 0);
      if (mem_ras_n && !p_ras && !cas_seen) begin
        chk(row_seen == exp_ref, "R7 refresh row", row_seen, exp_ref);
        exp_ref = exp_ref + 8'd1;
        ref_cnt++;
      end
      if (!mem_ras_n && p_ras) begin end
      if (rsp_valid) begin
        logic [1:0] e;
        chk(mem_cas_n && !p_cas, "R5 response timing", p_cas, 0);
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected response", 1, 0);
        else begin
          e = exp_q.pop_front();
          if (!e[1]) chk(rsp_rdata == e[0], "R5 read data", rsp_rdata, e[0]);
        end
      end
      hi_run = mem_ras_n ? hi_run + 1 : 0;
      p_ras = mem_ras_n; p_cas = mem_cas_n;
    end
  end

  // refresh start gap (R8, R9)
  logic g_ras = 1'b1;
  bit   g_first = 1'b1;
  int   g_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      g_cnt++;
      if (!mem_ras_n && g_ras && mem_addr == exp_ref && mem_cas_n) begin
        // candidate start; confirmed as refresh when no column strobe follows
      end
      if (mem_ras_n && !g_ras && !cas_seen) begin
        chk(g_cnt <= REF_I + SLACK, "R8 R9 refresh gap", g_cnt, REF_I + SLACK);
        g_cnt = 0;
        g_first = 1'b0;
      end
      if (g_cnt > REF_I + SLACK + 5 && g_first == 1'b0) begin
        chk(1'b0, "R8 R9 refresh starved", g_cnt, REF_I + SLACK);
        g_cnt = 0;
      end
      g_ras = mem_ras_n;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ras_n && mem_cas_n && mem_we_n, "R1 strobes idle", {mem_ras_n, mem_cas_n, mem_we_n}, 7);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);

    // R4 R5 corners
    issue(1, 16'h0000, 1); issue(1, 16'hFFFF, 1); issue(1, 16'h00FF, 0);
    issue(1, 16'hFF00, 1); issue(1, 16'h1234, 1);
    issue(0, 16'h0000, 0); issue(0, 16'hFFFF, 0); issue(0, 16'h00FF, 0);
    issue(0, 16'hFF00, 0); issue(0, 16'h1234, 0); issue(0, 16'h4321, 0);
    // overwrite
    issue(1, 16'h1234, 0); issue(0, 16'h1234, 0);
    // walking address bit
    for (int i = 0; i < 16; i++) issue(1, 16'(1 << i), i[0]);
    for (int i = 0; i < 16; i++) issue(0, 16'(1 << i), 0);
    // continuous stream across a full refresh wrap (R9, R7 wrap)
    while (ref_cnt < 262) begin
      logic [5:0] r;
      r = 6'($urandom);
      issue(1'($urandom), {r[5:3], 5'b10101, r[2:0], 5'b01010}, 1'($urandom));
    end
    // idle: refresh continues without requests
    repeat (4 * REF_I) @(negedge clk);
    while (exp_q.size() != 0) @(negedge clk);
    chk(ref_cnt >= 256, "R8 all rows refreshed", ref_cnt, 256);
    chk(addr_q.size() == 0, "R5 all accesses seen", addr_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule